// File: doc/BRIEF.md
# Receive Block Gearbox (64B/66B and 64B/67B)

This block sits between a receive deserializer and the user logic. Each clock it takes one recovered word of fixed width, in which bit 0 is the earliest bit off the line. It cuts the resulting bit stream into blocks made of a sync header and a 64-bit payload. The header is 2 bits in 66-bit framing and 3 bits in 67-bit framing. The payload is handed out as beats of 2, 4 or 8 bytes. The header for each block is reported on a separate field.

Every block carries more line bits than payload bits, so the buffer periodically lacks a full beat. On those cycles both valid strobes drop together. The block decides by itself when a beat is ready by counting the bits it holds, and no outside sequence counter is supplied to it. External lock logic searches for block alignment by pulsing a slip input. Each accepted pulse discards one bit, which moves the block boundary later by one bit position. After an accepted pulse, further pulses are ignored for a settling window.

Top module: `rx_gearbox`

## Requirements
- R1: The parameter USER_BYTES selects a payload beat width W of 16, 32 or 64 bits; any other value is rejected at elaboration.
- R2: Input bit 0 is the earliest received bit. In a block, the first received header bit appears on rx_hdr[0] and the second on rx_hdr[1]. The payload bit that follows the header appears on rx_data[0] of the first beat. Later beats carry the next W payload bits in the same order.
- R3: With mode67 low the header is 2 bits and rx_hdr[2] is 0. With mode67 high the header is 3 bits and all three are reported. mode67 changes only while rst is high.
- R4: rx_hdr_vld is high only together with rx_data_vld, and only on the first beat of a block. Between header-valid beats, rx_hdr holds its value.
- R5: With W=32, steady-state output has exactly 32 data-valid cycles and 16 header-valid cycles in any 33 cycles in 66-bit mode. In 67-bit mode it has 64 data-valid and 32 header-valid cycles in any 67 cycles. Outside those cycles both strobes are low.
- R6: A beat appears on the outputs right after the clock edge that samples the input word completing it. The outputs are registers.
- R7: An accepted slip pulse discards the oldest buffered bit, which moves the block boundary by exactly one bit.
- R8: After an accepted slip pulse, slip requests in the following SLIP_HOLD cycles are ignored.
- R9: While rst is high and on the first cycle after it, both strobes are low. The second input word after reset completes block 0, and its first beat carries header-valid.
- R10: No received bit is lost or repeated. Every block sent appears in order, and the buffer never holds more than BUF_W-W bits before a word is appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode67 | input | 1 | 0: 2-bit header framing, 1: 3-bit header framing |
| rx_word | input | W | Recovered line word, bit 0 earliest |
| slip_req | input | 1 | Request to discard one bit and shift the boundary |
| rx_data | output | W | Payload beat |
| rx_hdr | output | 3 | Sync header of the current block, bit 0 earliest |
| rx_data_vld | output | 1 | Payload beat valid |
| rx_hdr_vld | output | 1 | Header valid, first beat of a block only |

## Verification
A word driven before clock edge k shows its completed beat on the outputs after edge k. The bench drives at falling edges and samples one half period later, so the word driven in loop step c is judged in step c+1. The first valid beat after reset is therefore expected at step 2, and the invalid fill cycle at step 1. Beat and header contents are compared in arrival order from a queue, so no exact cycle is assumed for them. The pause rate is measured by counting strobes over a full 33- or 67-cycle window after the first beats have come out.

// File: rtl/rx_gbx_pkg.sv
package rx_gbx_pkg;
    localparam int HDR_MAX = 3;

    function automatic logic [1:0] hdr_len(input logic m67);
        return m67 ? 2'd3 : 2'd2;
    endfunction
endpackage

// File: rtl/rx_gbx_slip_guard.sv
module rx_gbx_slip_guard #(
    parameter int HOLD = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic drop
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        drop  = req && (cnt_q == '0);
        cnt_d = cnt_q;
        if (drop)
            cnt_d = CW'(HOLD);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rx_gbx_bitbuf.sv
module rx_gbx_bitbuf #(
    parameter int W     = 32,
    parameter int BUF_W = 2 * W + 3,
    parameter int CW    = $clog2(BUF_W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  word,
    input  logic          drop,
    input  logic          take_en,
    input  logic          take_hdr,
    input  logic [1:0]    hlen,
    output logic [CW-1:0] avail,
    output logic [W+2:0]  window
);
    typedef struct packed {
        logic [BUF_W-1:0] bits;
        logic [CW-1:0]    fill;
    } buf_t;

    buf_t             cur_q, nxt_d;
    logic [BUF_W-1:0] merged;
    logic [BUF_W-1:0] shifted;
    logic [CW-1:0]    consumed;

    always_comb begin
        merged   = cur_q.bits | ({{(BUF_W-W){1'b0}}, word} << cur_q.fill);
        shifted  = merged >> drop;
        avail    = cur_q.fill + CW'(W) - CW'(drop);
        window   = shifted[W+2:0];
        consumed = '0;
        if (take_en)
            consumed = take_hdr ? CW'(W) + CW'(hlen) : CW'(W);
        nxt_d.bits = shifted >> consumed;
        nxt_d.fill = avail - consumed;
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    // R10: room for one more word is always left
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cur_q.fill <= CW'(BUF_W - W));
endmodule

// File: rtl/rx_gearbox.sv
module rx_gearbox
    import rx_gbx_pkg::*;
#(
    parameter int USER_BYTES = 4,
    parameter int SLIP_HOLD  = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mode67,
    input  logic [USER_BYTES*8-1:0] rx_word,
    input  logic                    slip_req,
    output logic [USER_BYTES*8-1:0] rx_data,
    output logic [HDR_MAX-1:0]      rx_hdr,
    output logic                    rx_data_vld,
    output logic                    rx_hdr_vld
);
    localparam int W     = USER_BYTES * 8;
    localparam int BEATS = 64 / W;
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int BUF_W = 2 * W + HDR_MAX;
    localparam int CW    = $clog2(BUF_W + 1);

    initial begin
        a_r1_width_legal: assert (USER_BYTES == 2 || USER_BYTES == 4 || USER_BYTES == 8);
    end

    typedef struct packed {
        logic [W-1:0]         data;
        logic [HDR_MAX-1:0]   hdr;
        logic                 dv;
        logic                 hv;
        logic [BW-1:0]        beat;
    } st_t;

    st_t           st_d, st_q;
    logic          drop;
    logic [1:0]    hlen;
    logic [CW-1:0] avail;
    logic [CW-1:0] need;
    logic [W+2:0]  window;
    logic          first;
    logic          go;

    rx_gbx_slip_guard #(.HOLD(SLIP_HOLD)) u_slip (
        .clk  (clk),
        .rst  (rst),
        .req  (slip_req),
        .drop (drop)
    );

    rx_gbx_bitbuf #(.W(W), .BUF_W(BUF_W), .CW(CW)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .word     (rx_word),
        .drop     (drop),
        .take_en  (go),
        .take_hdr (first),
        .hlen     (hlen),
        .avail    (avail),
        .window   (window)
    );

    always_comb begin
        hlen  = hdr_len(mode67);
        first = (st_q.beat == '0);
        need  = CW'(W) + (first ? CW'(hlen) : CW'(0));
        go    = (avail >= need);

        st_d    = st_q;
        st_d.dv = go;
        st_d.hv = go && first;
        if (go) begin
            if (first) begin
                st_d.data = window[hlen +: W];
                st_d.hdr  = {mode67 & window[2], window[1:0]};
            end else begin
                st_d.data = window[W-1:0];
            end
            st_d.beat = (st_q.beat == BW'(BEATS - 1)) ? '0 : st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rx_data     = st_q.data;
    assign rx_hdr      = st_q.hdr;
    assign rx_data_vld = st_q.dv;
    assign rx_hdr_vld  = st_q.hv;

    // R4: header strobe never without a data beat
    a_r4_hdr_with_data: assert property (@(posedge clk) disable iff (rst)
        rx_hdr_vld |-> rx_data_vld);

    // R4: header field only moves on a header-valid beat
    a_r4_hdr_hold: assert property (@(posedge clk) disable iff (rst)
        !rx_hdr_vld |-> $stable(rx_hdr));

    // R3: third header bit stays clear in 2-bit framing
    a_r3_hdr66_top_clear: assert property (@(posedge clk) disable iff (rst)
        !mode67 |-> (rx_hdr[2] == 1'b0));

    // R8: two accepted slips are never back to back
    a_r8_slip_spaced: assert property (@(posedge clk) disable iff (rst)
        drop |=> !drop);

    // R9: strobes low in the cycle after a reset edge
    a_r9_reset_idle: assert property (@(posedge clk)
        rst |=> (!rx_data_vld && !rx_hdr_vld));
endmodule

// File: tb/sim_rx_gearbox.sv
module sim_rx_gearbox;
    localparam int CLK_P = 10;
    localparam int W     = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode67 = 1'b0;
    logic [W-1:0]  rx_word = '0;
    logic          slip_req = 1'b0;
    logic [W-1:0]  rx_data;
    logic [2:0]    rx_hdr;
    logic          rx_data_vld;
    logic          rx_hdr_vld;

    always #(CLK_P/2) clk = ~clk;

    rx_gearbox #(.USER_BYTES(4), .SLIP_HOLD(32)) u0 (
        .clk         (clk),
        .rst         (rst),
        .mode67      (mode67),
        .rx_word     (rx_word),
        .slip_req    (slip_req),
        .rx_data     (rx_data),
        .rx_hdr      (rx_hdr),
        .rx_data_vld (rx_data_vld),
        .rx_hdr_vld  (rx_hdr_vld)
    );

    typedef struct {
        logic [W-1:0] d;
        logic [2:0]   h;
        bit           first;
    } exp_t;

    bit     bitq[$];
    exp_t   expq[$];
    int     nvec  = 0;
    int     nfail = 0;
    bit     mon_en = 1'b0;
    bit     done = 1'b0;
    logic [63:0] seed = 64'h0123_4567_89ab_cdef;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver side: build stream, push expected beats
    task automatic build(input bit m67, input int nblk, input int junk);
        for (int j = 0; j < junk; j++) bitq.push_back(1'b1);
        for (int b = 0; b < nblk; b++) begin
            logic [2:0]  h;
            logic [63:0] p;
            exp_t        e;
            seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
            p = seed;
            h = m67 ? 3'((b * 5 + 1) & 7) : (b[0] ? 3'b010 : 3'b001);
            for (int k = 0; k < (m67 ? 3 : 2); k++) bitq.push_back(h[k]);
            for (int k = 0; k < 64; k++) bitq.push_back(p[k]);
            for (int t = 0; t < 64 / W; t++) begin
                e.d = p[t*W +: W];
                e.h = h;
                e.first = (t == 0);
                expq.push_back(e);
            end
        end
    endtask

    // monitor: compare beats in arrival order (R2, R3, R4, R7, R10)
    always @(negedge clk) begin
        if (mon_en && rx_data_vld && expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            chk(rx_data == e.d, "R2/R10 data", rx_data, e.d);
            chk(rx_hdr_vld == e.first, "R4 hdr_vld", rx_hdr_vld, e.first);
            if (e.first) chk(rx_hdr == e.h, "R2/R3 hdr", rx_hdr, e.h);
        end
    end

    task automatic run_phase(input bit m67, input int nblk, input int junk,
                             input int slip_a, input int slip_b,
                             input int wlo, input int wlen, input int expv, input int exph);
        int vc = 0;
        int hc = 0;
        int ncyc;
        bitq.delete();
        expq.delete();
        build(m67, nblk, junk);
        rst = 1'b1; mode67 = m67; slip_req = 1'b0; rx_word = '0;
        repeat (3) @(negedge clk);
        chk(!rx_data_vld && !rx_hdr_vld, "R9 idle in reset", {rx_data_vld, rx_hdr_vld}, 0);
        rst = 1'b0;
        mon_en = 1'b1;
        ncyc = bitq.size() / W + 12;
        for (int c = 0; c < ncyc; c++) begin
            if (c == 1) chk(!rx_data_vld, "R9 fill cycle", rx_data_vld, 0);
            if (c == 2) chk(rx_data_vld && rx_hdr_vld, "R6/R9 first beat",
                            {rx_data_vld, rx_hdr_vld}, 3);
            if (wlen > 0 && c >= wlo && c < wlo + wlen) begin
                vc += int'(rx_data_vld);
                hc += int'(rx_hdr_vld);
            end
            for (int k = 0; k < W; k++)
                rx_word[k] = (bitq.size() > 0) ? bitq.pop_front() : 1'b0;
            slip_req = (c == slip_a) || (c == slip_b);
            @(negedge clk);
        end
        slip_req = 1'b0;
        if (wlen > 0) begin
            chk(vc == expv, "R5 data-valid rate", vc, expv);
            chk(hc == exph, "R5 header-valid rate", hc, exph);
        end
        chk(expq.size() == 0, "R10 all blocks delivered", expq.size(), 0);
        mon_en = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        // 66-bit framing, pause every 33 cycles (R3, R5)
        run_phase(1'b0, 48, 0, -1, -1, 4, 33, 32, 16);
        // 67-bit framing, 3 pauses per 67 cycles (R3, R5)
        run_phase(1'b1, 48, 0, -1, -1, 4, 67, 64, 32);
        // one junk bit removed by slip R7; second slip inside hold ignored R8
        run_phase(1'b0, 24, 1, 0, 10, 0, 0, 0, 0);
        // same in 67-bit framing with a slip just inside the hold window R8
        run_phase(1'b1, 24, 1, 0, 32, 0, 0, 0, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule